// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block holds one reservation for an atomic read-modify-write sequence. A load-reserve request records the granule it touches and marks the reservation valid. A later store-conditional request is checked against that record and reports whether it may complete. Every accepted store-conditional drops the reservation, whatever its outcome. A snoop port carries the addresses of writes made by other agents. A snooped write that lands in the reserved granule cancels the reservation.

A granule is an aligned 32-byte block, so addresses are compared with their five low bits removed. Both request kinds must be word aligned. Neither may target a region marked write-through. A request that breaks either rule raises an exception pulse and leaves the reservation exactly as it was. Results come out as registered single-cycle pulses, one cycle after the request. The memory access itself is performed elsewhere.

Top module: `resv_unit`

## Requirements
- R1: Two addresses fall in the same granule when they are equal after the low 5 address bits are dropped. Their low bits play no part in the comparison.
- R2: A store-conditional (`req_kind`=1) raises `sc_ok` only if a reservation is valid and its granule equals the granule of the request.
- R3: A request of either kind whose address bits [1:0] are not 00 raises `align_exc`.
- R4: A word-aligned request of either kind with `req_wthru`=1 raises `dsi_exc`. A misaligned request raises only `align_exc`, whatever `req_wthru` is.
- R5: A request that raises an exception leaves the reservation unchanged. It neither sets it, checks it nor clears it.
- R6: Every accepted store-conditional clears the reservation, whether it succeeds or fails.
- R7: A snooped write (`snp_valid`=1) whose granule matches the valid reservation clears the reservation at the next edge. A store-conditional to that granule in the same cycle fails. A snooped write to another granule has no effect.
- R8: An accepted load-reserve (`req_kind`=0) replaces any existing reservation with its own granule.
- R9: `sc_ok`, `align_exc` and `dsi_exc` each pulse for exactly one cycle, in the cycle after the request. At most one of them is high at a time, and all three are low out of reset and after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 1 | 0 = load-reserve, 1 = store-conditional |
| req_addr | input | ADDR_W | Effective address of the request |
| req_wthru | input | 1 | Target region is write-through |
| snp_valid | input | 1 | External write observed this cycle |
| snp_addr | input | ADDR_W | Address of the external write |
| sc_ok | output | 1 | Store-conditional succeeded (pulse) |
| align_exc | output | 1 | Alignment exception (pulse) |
| dsi_exc | output | 1 | Data-storage exception (pulse) |

## Verification
The assertions assume that `req_kind`, `req_addr` and `req_wthru` are held at known values whenever `req_valid` is high. They also assume that every input is at a known value during the first cycle after reset. The stimulus meets both assumptions by driving all inputs to zero during reset and changing them only on the falling clock edge. The snoop checks need a snooped write that coincides with no request. The bench therefore presents such writes in idle cycles, and adds one separate directed case in which a snoop and a store-conditional arrive together.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic {
    KIND_LOAD_RES   = 1'b0,
    KIND_STORE_COND = 1'b1
  } req_kind_e;

  typedef struct packed {
    logic ok;
    logic align;
    logic dsi;
  } resp_t;

endpackage

// File: rtl/resv_classify.sv
module resv_classify
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wthru,
  output logic              acc_lr,
  output logic              acc_sc,
  output logic              flt_align,
  output logic              flt_wthru
);

  logic misaligned;

  always_comb begin
    misaligned = |req_addr[ALIGN_BITS-1:0];
    flt_align  = req_valid && misaligned;
    flt_wthru  = req_valid && !misaligned && req_wthru;
    acc_lr     = req_valid && !misaligned && !req_wthru &&
                 (req_kind_e'(req_kind) == KIND_LOAD_RES);
    acc_sc     = req_valid && !misaligned && !req_wthru &&
                 (req_kind_e'(req_kind) == KIND_STORE_COND);
  end

endmodule

// File: rtl/resv_track.sv
module resv_track #(
  parameter int GRAN_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_lr,
  input  logic              acc_sc,
  input  logic [GRAN_W-1:0] req_gran,
  input  logic              snp_valid,
  input  logic [GRAN_W-1:0] snp_gran,
  output logic              sc_pass,
  output logic              resv_vld,
  output logic [GRAN_W-1:0] resv_gran
);

  logic              vld_nxt;
  logic [GRAN_W-1:0] gran_nxt;
  logic              gran_en;
  logic              snp_hit_old;
  logic              snp_hit_new;

  always_comb begin
    snp_hit_old = snp_valid && resv_vld && (snp_gran == resv_gran);
    snp_hit_new = snp_valid && (snp_gran == req_gran);
    sc_pass     = acc_sc && resv_vld && (resv_gran == req_gran) && !snp_hit_old;
    gran_en     = acc_lr;
    gran_nxt    = req_gran;
    vld_nxt     = resv_vld;
    if (acc_lr) begin
      vld_nxt = !snp_hit_new;
    end else if (acc_sc) begin
      vld_nxt = 1'b0;
    end else if (snp_hit_old) begin
      vld_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_vld <= 1'b0;
    end else begin
      resv_vld <= vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_gran <= '0;
    end else if (gran_en) begin
      resv_gran <= gran_nxt;
    end
  end

endmodule

// File: rtl/resv_pulse.sv
module resv_pulse
  import resv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sc_pass,
  input  logic flt_align,
  input  logic flt_wthru,
  output logic sc_ok,
  output logic align_exc,
  output logic dsi_exc
);

  resp_t resp_q;
  resp_t resp_d;

  always_comb begin
    resp_d.ok    = sc_pass;
    resp_d.align = flt_align;
    resp_d.dsi   = flt_wthru;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= '0;
    end else begin
      resp_q <= resp_d;
    end
  end

  assign sc_ok     = resp_q.ok;
  assign align_exc = resp_q.align;
  assign dsi_exc   = resp_q.dsi;

endmodule

// File: rtl/resv_unit.sv
module resv_unit #(
  parameter int ADDR_W     = 32,
  parameter int GRAN_BITS  = 5,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wthru,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              sc_ok,
  output logic              align_exc,
  output logic              dsi_exc
);

  localparam int GRAN_W = ADDR_W - GRAN_BITS;

  logic              acc_lr;
  logic              acc_sc;
  logic              flt_align;
  logic              flt_wthru;
  logic              sc_pass;
  logic              resv_vld;
  logic [GRAN_W-1:0] resv_gran;
  logic [GRAN_W-1:0] req_gran;
  logic [GRAN_W-1:0] snp_gran;

  assign req_gran = req_addr[ADDR_W-1:GRAN_BITS];
  assign snp_gran = snp_addr[ADDR_W-1:GRAN_BITS];

  resv_classify #(
    .ADDR_W    (ADDR_W),
    .ALIGN_BITS(ALIGN_BITS)
  ) u_classify (
    .req_valid(req_valid),
    .req_kind (req_kind),
    .req_addr (req_addr),
    .req_wthru(req_wthru),
    .acc_lr   (acc_lr),
    .acc_sc   (acc_sc),
    .flt_align(flt_align),
    .flt_wthru(flt_wthru)
  );

  resv_track #(
    .GRAN_W(GRAN_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_lr   (acc_lr),
    .acc_sc   (acc_sc),
    .req_gran (req_gran),
    .snp_valid(snp_valid),
    .snp_gran (snp_gran),
    .sc_pass  (sc_pass),
    .resv_vld (resv_vld),
    .resv_gran(resv_gran)
  );

  resv_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .sc_pass  (sc_pass),
    .flt_align(flt_align),
    .flt_wthru(flt_wthru),
    .sc_ok    (sc_ok),
    .align_exc(align_exc),
    .dsi_exc  (dsi_exc)
  );

endmodule

// File: rtl/resv_unit_chk.sv
module resv_unit_chk #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_kind,
  input logic [ADDR_W-1:0]           req_addr,
  input logic                        req_wthru,
  input logic                        snp_valid,
  input logic [ADDR_W-1:0]           snp_addr,
  input logic                        sc_ok,
  input logic                        align_exc,
  input logic                        dsi_exc,
  input logic                        resv_vld,
  input logic [ADDR_W-GRAN_BITS-1:0] resv_gran
);

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sc_ok, align_exc, dsi_exc}));

  // R2
  sc_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind && (req_addr[1:0] == 2'b00) && !req_wthru &&
     !resv_vld) |=> !sc_ok);

  // R3
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[1:0] != 2'b00)) |=> align_exc);

  // R4
  dsi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[1:0] == 2'b00) && req_wthru) |=> (dsi_exc && !align_exc));

  // R6
  sc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind && (req_addr[1:0] == 2'b00) && !req_wthru) |=> !resv_vld);

  // R5
  exc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_addr[1:0] != 2'b00) || req_wthru) && !snp_valid) |=>
      ($stable(resv_vld) && $stable(resv_gran)));

  // R7
  snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && snp_valid && resv_vld &&
     (snp_addr[ADDR_W-1:GRAN_BITS] == resv_gran)) |=> !resv_vld);

  // R8
  lr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind && (req_addr[1:0] == 2'b00) && !req_wthru && !snp_valid) |=>
      (resv_vld && (resv_gran == $past(req_addr[ADDR_W-1:GRAN_BITS]))));

endmodule

bind resv_unit resv_unit_chk #(
  .ADDR_W   (ADDR_W),
  .GRAN_BITS(GRAN_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_kind (req_kind),
  .req_addr (req_addr),
  .req_wthru(req_wthru),
  .snp_valid(snp_valid),
  .snp_addr (snp_addr),
  .sc_ok    (sc_ok),
  .align_exc(align_exc),
  .dsi_exc  (dsi_exc),
  .resv_vld (resv_vld),
  .resv_gran(resv_gran)
);

// File: tb/tb_resv_unit.sv
module tb_resv_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef struct {
    logic  ok;
    logic  al;
    logic  ds;
    string tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_kind;
  logic [AW-1:0] req_addr;
  logic          req_wthru;
  logic          snp_valid;
  logic [AW-1:0] snp_addr;
  logic          sc_ok;
  logic          align_exc;
  logic          dsi_exc;

  int   n_chk;
  int   n_bad;
  exp_t sb_q[$];

  logic          m_vld;
  logic [AW-6:0] m_gran;

  resv_unit dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .req_addr (req_addr),
    .req_wthru(req_wthru),
    .snp_valid(snp_valid),
    .snp_addr (snp_addr),
    .sc_ok    (sc_ok),
    .align_exc(align_exc),
    .dsi_exc  (dsi_exc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step(input logic v, input logic k, input logic [AW-1:0] a,
                      input logic wt, input logic sv, input logic [AW-1:0] sa,
                      input string tag);
    exp_t e;
    logic sh;
    @(negedge clk);
    req_valid = v; req_kind = k; req_addr = a; req_wthru = wt;
    snp_valid = sv; snp_addr = sa;
    e.tag = tag;
    e.al  = v && (a[1:0] != 2'b00);
    e.ds  = v && !e.al && wt;
    e.ok  = 1'b0;
    sh    = sv && m_vld && (sa[AW-1:5] == m_gran);
    if (v && !e.al && !e.ds) begin
      if (!k) begin
        m_vld  = !(sv && (sa[AW-1:5] == a[AW-1:5]));
        m_gran = a[AW-1:5];
      end else begin
        e.ok  = m_vld && (m_gran == a[AW-1:5]) && !sh;
        m_vld = 1'b0;
      end
    end else if (sh) begin
      m_vld = 1'b0;
    end
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic lr(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b0, a, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic sc(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b1, a, 1'b0, 1'b0, '0, tag);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if ({sc_ok, align_exc, dsi_exc} !== {e.ok, e.al, e.ds}) begin
        n_bad++;
        $display("FAIL %s: ok/al/ds actual=%b%b%b expected=%b%b%b",
                 e.tag, sc_ok, align_exc, dsi_exc, e.ok, e.al, e.ds);
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; m_vld = 1'b0; m_gran = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 1'b0; req_addr = '0;
    req_wthru = 1'b0; snp_valid = 1'b0; snp_addr = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 4);
    n_chk++;
    if ({sc_ok, align_exc, dsi_exc} !== 3'b000) begin
      n_bad++;
      $display("FAIL R9 reset: actual=%b%b%b expected=000", sc_ok, align_exc, dsi_exc);
    end
    @(negedge clk); rst_n = 1'b1;

    idle("R9 idle after reset");
    sc(32'h0000_1000, "R2 sc without reservation");
    lr(32'h0000_1004, "R8 lr");
    sc(32'h0000_101C, "R1 R2 same granule other offset");
    idle("R9 pulse drops");
    sc(32'h0000_1004, "R6 second sc fails");
    lr(32'h0000_2000, "R8 lr");
    sc(32'h0000_2020, "R1 R2 adjacent granule fails");
    sc(32'h0000_2000, "R6 cleared after failed sc");
    lr(32'h0000_3000, "R8 lr");
    sc(32'h0000_3002, "R3 R5 misaligned sc");
    sc(32'h0000_3001, "R3 misaligned sc bit0");
    step(1'b1, 1'b1, 32'h0000_3000, 1'b1, 1'b0, '0, "R4 R5 write-through sc");
    sc(32'h0000_3008, "R5 reservation kept");
    step(1'b1, 1'b0, 32'h0000_4000, 1'b1, 1'b0, '0, "R4 R5 write-through lr");
    sc(32'h0000_4000, "R5 no reservation set");
    step(1'b1, 1'b0, 32'h0000_4003, 1'b1, 1'b0, '0, "R4 misaligned write-through");
    lr(32'h0000_5000, "R8 lr first");
    lr(32'h0000_6000, "R8 lr replaces");
    sc(32'h0000_5000, "R8 old granule fails");
    lr(32'h0000_7000, "R8 lr");
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, 32'h0000_7040, "R7 snoop other granule");
    sc(32'h0000_7010, "R7 reservation survives");
    lr(32'h0000_8000, "R8 lr");
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, 32'h0000_801F, "R7 snoop hit");
    sc(32'h0000_8000, "R7 sc after snoop fails");
    lr(32'h0000_9000, "R8 lr");
    step(1'b1, 1'b1, 32'h0000_9000, 1'b0, 1'b1, 32'h0000_9010, "R7 snoop with sc");
    lr(32'h0000_A000, "R8 lr");
    step(1'b1, 1'b0, 32'h0000_A002, 1'b0, 1'b0, '0, "R3 misaligned lr");
    sc(32'h0000_A000, "R5 R2 success after faulted lr");
    lr(32'hFFFF_FFE0, "R1 top granule lr");
    sc(32'hFFFF_FFFC, "R1 top granule sc");
    idle("R9 final idle");
    idle("R9 drain");
    repeat (3) @(posedge clk);
    #1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule